// File: doc/BRIEF.md
# Parallel Display Bus Write Controller

This block sends command and pixel bytes to a display panel over a parallel write-only bus. One sequencer serves both common bus styles. In the strobed-write style, a dedicated active-low write strobe latches each word. In the enable-clocked style, one pin selects read or write and a separate enable pulse latches each word. A mode input picks the style and the bus width (8, 9 or 16 bits). A transaction opens the chip-select window and may send one command byte. It then streams data words that the host offers through a valid/ready handshake. The window closes only after the last word.

The host starts a transaction with a one-cycle start pulse. At that edge the block samples the mode, the command byte, the command-present flag, the no-data flag and three phase lengths. A frame write is a transaction whose command-present flag is clear. A separate request drives a panel reset pulse of programmable length. While a transaction or a reset pulse is running, the busy output is high and new start or reset requests are dropped.

Top module: `pbus_wr_ctrl`

## Requirements
- R1: `mode_i` at start selects the bus style and width. 0/1/2 are strobed-write at 8/9/16 bits, and 3/4/5 are enable-clocked at 8/9/16 bits. Data bus bits above the selected width stay 0.
- R2: A start with `mode_i` of 6 or 7 pulses `err_o` high for exactly one cycle. It causes no chip select, no strobe and no busy.
- R3: `disp_cs_n_o` (active low) falls at the edge that accepts a start. It stays low through every transfer and rises only after the hold phase of the last transfer.
- R4: With `cmd_present_i` = 1, the first transfer carries `cmd_i` with `disp_dc_o` = 0. With `cmd_present_i` = 0, no command transfer occurs.
- R5: Every data transfer has `disp_dc_o` = 1. With `no_data_i` = 1, the window closes after the optional command without any data transfer.
- R6: In the strobed-write style, `disp_wr_o` goes low, the word then appears on the data bus, and `disp_wr_o` returns high. The rising edge is the latch point. `disp_en_o` stays 0.
- R7: In the enable-clocked style, `disp_wr_o` (read/write select, 0 = write) is low for the whole window. `disp_en_o` rises, the word appears, and `disp_en_o` falls as the latch point. `disp_wr_o` returns to 1 when the window closes.
- R8: After reset: `disp_cs_n_o`=1, `disp_dc_o`=0, `disp_wr_o`=1, `disp_rd_o`=1, `disp_en_o`=0, `disp_rst_o`=0, `disp_d_o`=0, `busy_o`=0, `dat_ready_o`=0.
- R9: A reset request raises `disp_rst_o` for `rst_len_i` cycles (0 counts as 1) and then lowers it. If a start and a reset request arrive in the same idle cycle, the reset request wins.
- R10: Each transfer has a setup, an active and a hold phase, lasting `t_setup_i`, `t_active_i` and `t_hold_i` cycles (0 counts as 1). The strobe is active for setup plus active cycles. The word is stable from the start of the active phase through the hold phase.
- R11: `busy_o` is high from the accepted start until chip select rises, and also during a reset pulse. Start and reset requests are ignored while busy.
- R12: If no data word is offered, no strobe occurs and the window stays open with `dat_ready_o` = 1. A word is taken in a cycle where `dat_valid_i` and `dat_ready_o` are both high, and `dat_last_i` marks the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Bus style and width code, sampled at start |
| cmd_present_i | input | 1 | Send a command transfer first |
| cmd_i | input | 8 | Command byte |
| no_data_i | input | 1 | Skip the data phase |
| t_setup_i | input | CNT_W | Setup phase length in cycles |
| t_active_i | input | CNT_W | Active phase length in cycles |
| t_hold_i | input | CNT_W | Hold phase length in cycles |
| start_i | input | 1 | Start a transaction |
| dat_valid_i | input | 1 | Data word offered |
| dat_i | input | BUS_W | Data word |
| dat_last_i | input | 1 | Offered word is the final one |
| dat_ready_o | output | 1 | Block takes a word this cycle if valid |
| rst_req_i | input | 1 | Request a panel reset pulse |
| rst_len_i | input | RST_W | Reset pulse length in cycles |
| busy_o | output | 1 | Transaction or reset pulse running |
| err_o | output | 1 | Unsupported mode pulse |
| disp_cs_n_o | output | 1 | Panel chip select, active low |
| disp_dc_o | output | 1 | Data (1) or command (0) select |
| disp_wr_o | output | 1 | Write strobe or read/write select |
| disp_rd_o | output | 1 | Read strobe, held inactive high |
| disp_en_o | output | 1 | Enable strobe, enable-clocked style |
| disp_rst_o | output | 1 | Panel reset, active high |
| disp_d_o | output | BUS_W | Panel data bus |

## Verification
The hardest situation to reach from the ports is a request that arrives while the window is held open by a stalled data stream. At that point the block is busy but nothing moves on the bus. The bench starts a command transaction and then withholds the data word. While chip select is low and no strobe occurs, it issues a reset request and a second start with a different command. It then feeds the word and confirms that only the original command and word were sent and that no reset pulse appeared. Table entries with a gap flag also drop valid mid-stream, so the bench can check that the strobe count freezes while chip select stays low.

// File: rtl/pbus_pkg.sv
// Shared types for the parallel display bus write controller.
// Assumes mode codes 0..5 are legal and 6..7 are rejected.
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_FETCH,
        ST_SETUP,
        ST_ACTIVE,
        ST_HOLD,
        ST_CLOSE
    } seq_state_t;

    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_9  = 2'd1,
        BW_16 = 2'd2
    } bus_width_t;

    typedef struct packed {
        logic       ok;
        logic       enable_style;
        bus_width_t width;
    } mode_info_t;

    // Decode the 3-bit mode into style, width and legality.
    function automatic mode_info_t decode_mode(input logic [2:0] m);
        mode_info_t r;
        r.ok           = 1'b1;
        r.enable_style = 1'b0;
        r.width        = BW_8;
        case (m)
            3'd0: r.width = BW_8;
            3'd1: r.width = BW_9;
            3'd2: r.width = BW_16;
            3'd3: begin r.enable_style = 1'b1; r.width = BW_8;  end
            3'd4: begin r.enable_style = 1'b1; r.width = BW_9;  end
            3'd5: begin r.enable_style = 1'b1; r.width = BW_16; end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
// Down-counter that times one strobe phase.
// A load sets the phase length (0 treated as 1); done_o is high in the
// last cycle of the phase. Assumes the owner loads on every phase entry.
module pbus_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the phase length minus one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && len_i > CNT_W'(1)) |=> !done_o) else $error("timer reload");  // R10
endmodule

// File: rtl/pbus_rst_gen.sv
// Panel reset pulse generator. Starts a pulse of len_i cycles (0 as 1)
// when req_i is seen while allow_i is high and no pulse is running.
module pbus_rst_gen #(
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             allow_i,
    input  logic [RST_W-1:0] len_i,
    output logic             pulse_o
);
    logic [RST_W-1:0] cnt_q;
    logic             pulse_q;

    // Launch a pulse on a granted request and end it when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!pulse_q) begin
            if (req_i && allow_i) begin
                pulse_q <= 1'b1;
                cnt_q   <= (len_i == '0) ? '0 : len_i - RST_W'(1);
            end
        end else if (cnt_q == '0) begin
            pulse_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - RST_W'(1);
        end
    end

    assign pulse_o = pulse_q;

    AST_RST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $past(req_i && allow_i)) else $error("reset grant");  // R9
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && cnt_q != '0) |=> pulse_q) else $error("reset hold");  // R9
endmodule

// File: rtl/pbus_width_mask.sv
// Clears the data bus bits above the selected width.
// Bits 0..7 always pass, bit 8 passes for 9 and 16 bits, the rest only for 16.
module pbus_width_mask
    import pbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  bus_width_t       width_i,
    input  logic [BUS_W-1:0] val_i,
    output logic [BUS_W-1:0] d_o
);
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        if (i < 8) begin : g_low
            assign d_o[i] = val_i[i];
        end else if (i == 8) begin : g_ninth
            assign d_o[i] = val_i[i] & (width_i != BW_8);
        end else begin : g_high
            assign d_o[i] = val_i[i] & (width_i == BW_16);
        end
    end
endmodule

// File: rtl/pbus_seq.sv
// Transaction sequencer: opens chip select, runs the optional command
// transfer, then pulls data words through the handshake, timing each
// transfer as setup / active / hold. Assumes the phase timer is loaded by
// tmr_ld_o and reports done_o in the last cycle of each phase.
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             blocked_i,
    input  logic [2:0]       mode_i,
    input  logic             cmd_present_i,
    input  logic [7:0]       cmd_i,
    input  logic             no_data_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_active_i,
    input  logic [CNT_W-1:0] t_hold_i,
    input  logic             dat_valid_i,
    input  logic [BUS_W-1:0] dat_i,
    input  logic             dat_last_i,
    output logic             dat_ready_o,
    output logic             busy_o,
    output logic             err_o,
    output logic             cs_n_o,
    output logic             dc_o,
    output logic             wr_o,
    output logic             en_o,
    output logic [BUS_W-1:0] d_raw_o,
    output bus_width_t       width_o,
    output logic             tmr_ld_o,
    output logic [CNT_W-1:0] tmr_len_o,
    input  logic             tmr_done_i
);
    seq_state_t       state_q;
    mode_info_t       info;
    logic             en_style_q, cmd_q, nodata_q, last_q, err_q;
    logic             cs_n_q, dc_q, wr_q, en_q;
    logic [BUS_W-1:0] val_q, d_q;
    bus_width_t       width_q;
    logic [CNT_W-1:0] ts_q, ta_q, th_q;

    assign info = decode_mode(mode_i);

    // Select when the phase timer is loaded and with which length.
    always_comb begin
        tmr_ld_o  = 1'b0;
        tmr_len_o = ts_q;
        case (state_q)
            ST_OPEN:   if (cmd_q)       begin tmr_ld_o = 1'b1; tmr_len_o = ts_q; end
            ST_FETCH:  if (dat_valid_i) begin tmr_ld_o = 1'b1; tmr_len_o = ts_q; end
            ST_SETUP:  if (tmr_done_i)  begin tmr_ld_o = 1'b1; tmr_len_o = ta_q; end
            ST_ACTIVE: if (tmr_done_i)  begin tmr_ld_o = 1'b1; tmr_len_o = th_q; end
            default: ;
        endcase
    end

    // Main sequencer: state, bus pins and sampled transaction settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            en_style_q <= 1'b0;
            cmd_q      <= 1'b0;
            nodata_q   <= 1'b0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            dc_q       <= 1'b0;
            wr_q       <= 1'b1;
            en_q       <= 1'b0;
            val_q      <= '0;
            d_q        <= '0;
            width_q    <= BW_8;
            ts_q       <= '0;
            ta_q       <= '0;
            th_q       <= '0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && !blocked_i) begin
                        if (!info.ok) begin
                            err_q <= 1'b1;
                        end else begin
                            state_q    <= ST_OPEN;
                            cs_n_q     <= 1'b0;
                            dc_q       <= !cmd_present_i;
                            wr_q       <= !info.enable_style;
                            en_style_q <= info.enable_style;
                            width_q    <= info.width;
                            cmd_q      <= cmd_present_i;
                            nodata_q   <= no_data_i;
                            last_q     <= 1'b0;
                            val_q      <= BUS_W'(cmd_i);
                            ts_q       <= t_setup_i;
                            ta_q       <= t_active_i;
                            th_q       <= t_hold_i;
                        end
                    end
                end
                ST_OPEN: begin
                    if (cmd_q) begin
                        state_q <= ST_SETUP;
                        if (en_style_q) en_q <= 1'b1;
                        else            wr_q <= 1'b0;
                    end else if (nodata_q) begin
                        state_q <= ST_CLOSE;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (dat_valid_i) begin
                        val_q   <= dat_i;
                        last_q  <= dat_last_i;
                        state_q <= ST_SETUP;
                        if (en_style_q) en_q <= 1'b1;
                        else            wr_q <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (tmr_done_i) begin
                        state_q <= ST_ACTIVE;
                        d_q     <= val_q;
                    end
                end
                ST_ACTIVE: begin
                    if (tmr_done_i) begin
                        state_q <= ST_HOLD;
                        if (en_style_q) en_q <= 1'b0;
                        else            wr_q <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr_done_i) begin
                        if (cmd_q) begin
                            cmd_q <= 1'b0;
                            if (nodata_q) begin
                                state_q <= ST_CLOSE;
                            end else begin
                                dc_q    <= 1'b1;
                                state_q <= ST_FETCH;
                            end
                        end else if (last_q) begin
                            state_q <= ST_CLOSE;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_CLOSE: begin
                    cs_n_q  <= 1'b1;
                    wr_q    <= 1'b1;
                    dc_q    <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dat_ready_o = (state_q == ST_FETCH);
    assign busy_o      = (state_q != ST_IDLE);
    assign err_o       = err_q;
    assign cs_n_o      = cs_n_q;
    assign dc_o        = dc_q;
    assign wr_o        = wr_q;
    assign en_o        = en_q;
    assign d_raw_o     = d_q;
    assign width_o     = width_q;

    AST_CS_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_SETUP, ST_ACTIVE, ST_HOLD}) |-> !cs_n_q) else $error("cs");  // R3
    AST_DC_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && cmd_q) |-> !dc_q) else $error("dc cmd");  // R4
    AST_DC_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && !cmd_q) |-> dc_q) else $error("dc data");  // R5
    AST_EN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_style_q |-> !en_q) else $error("en in strobed style");  // R6
    AST_RW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_style_q && !cs_n_q) |-> !wr_q) else $error("rw select");  // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (cs_n_q && state_q == ST_IDLE)) else $error("err activity");  // R2
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) inside {ST_ACTIVE, ST_HOLD}) |-> $stable(d_q))
        else $error("data moved");  // R10
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !dat_valid_i) |=> (state_q == ST_FETCH && !en_q && wr_q == !en_style_q))
        else $error("stall");  // R12
endmodule

// File: rtl/pbus_wr_ctrl.sv
// Top of the parallel display bus write controller: joins the sequencer,
// its phase timer, the panel reset generator and the width mask.
// Assumes start_i and rst_req_i are single-cycle requests from the host.
module pbus_wr_ctrl
    import pbus_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BUS_W = 16,
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             cmd_present_i,
    input  logic [7:0]       cmd_i,
    input  logic             no_data_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_active_i,
    input  logic [CNT_W-1:0] t_hold_i,
    input  logic             start_i,
    input  logic             dat_valid_i,
    input  logic [BUS_W-1:0] dat_i,
    input  logic             dat_last_i,
    output logic             dat_ready_o,
    input  logic             rst_req_i,
    input  logic [RST_W-1:0] rst_len_i,
    output logic             busy_o,
    output logic             err_o,
    output logic             disp_cs_n_o,
    output logic             disp_dc_o,
    output logic             disp_wr_o,
    output logic             disp_rd_o,
    output logic             disp_en_o,
    output logic             disp_rst_o,
    output logic [BUS_W-1:0] disp_d_o
);
    logic             seq_busy, pulse, tmr_ld, tmr_done;
    logic [CNT_W-1:0] tmr_len;
    logic [BUS_W-1:0] d_raw;
    bus_width_t       width;

    pbus_seq #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .blocked_i(pulse | rst_req_i),
        .mode_i(mode_i), .cmd_present_i(cmd_present_i), .cmd_i(cmd_i),
        .no_data_i(no_data_i),
        .t_setup_i(t_setup_i), .t_active_i(t_active_i), .t_hold_i(t_hold_i),
        .dat_valid_i(dat_valid_i), .dat_i(dat_i), .dat_last_i(dat_last_i),
        .dat_ready_o(dat_ready_o), .busy_o(seq_busy), .err_o(err_o),
        .cs_n_o(disp_cs_n_o), .dc_o(disp_dc_o), .wr_o(disp_wr_o), .en_o(disp_en_o),
        .d_raw_o(d_raw), .width_o(width),
        .tmr_ld_o(tmr_ld), .tmr_len_o(tmr_len), .tmr_done_i(tmr_done)
    );

    pbus_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ld_i(tmr_ld), .len_i(tmr_len), .done_o(tmr_done)
    );

    pbus_rst_gen #(.RST_W(RST_W)) u_rst (
        .clk(clk), .rst_n(rst_n), .req_i(rst_req_i),
        .allow_i(!seq_busy), .len_i(rst_len_i), .pulse_o(pulse)
    );

    pbus_width_mask #(.BUS_W(BUS_W)) u_mask (
        .width_i(width), .val_i(d_raw), .d_o(disp_d_o)
    );

    assign busy_o     = seq_busy | pulse;
    assign disp_rst_o = pulse;
    assign disp_rd_o  = 1'b1;

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !pulse) else $error("reset during transaction");  // R11
    AST_NO_START_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> disp_cs_n_o) else $error("start during reset pulse");  // R11
endmodule

// File: tb/sim_pbus_wr_ctrl.sv
`timescale 1ns/1ps
module sim_pbus_wr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic        cp = 1'b0, nodata = 1'b0, start = 1'b0, rst_req = 1'b0;
    logic [7:0]  cmd = '0, ts = 8'd1, ta = 8'd1, th = 8'd1;
    logic        dvalid = 1'b0, dlast = 1'b0;
    logic [15:0] dat = '0, rst_len = '0;
    logic        dready, busy, err, cs_n, dc, wr, rd, en, prst;
    logic [15:0] dbus;

    always #10 clk = ~clk;

    pbus_wr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmd_present_i(cp), .cmd_i(cmd),
        .no_data_i(nodata), .t_setup_i(ts), .t_active_i(ta), .t_hold_i(th),
        .start_i(start), .dat_valid_i(dvalid), .dat_i(dat), .dat_last_i(dlast),
        .dat_ready_o(dready), .rst_req_i(rst_req), .rst_len_i(rst_len),
        .busy_o(busy), .err_o(err), .disp_cs_n_o(cs_n), .disp_dc_o(dc),
        .disp_wr_o(wr), .disp_rd_o(rd), .disp_en_o(en), .disp_rst_o(prst),
        .disp_d_o(dbus)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor: records every latch edge with the word, dc and strobe length.
    bit mon_type_a = 1'b0;
    int cap_d [256];
    int cap_dc [256];
    int cap_len [256];
    int cap_n = 0, strb_cnt = 0, bad_en = 0, bad_rw = 0, bad_cs = 0, bad_rd = 0;
    logic prev_s = 1'b0, prev_dc = 1'b0;
    logic [15:0] prev_d = '0;
    always @(negedge clk) begin
        logic s;
        s = mon_type_a ? en : !wr;
        if (rst_n) begin
            if (rd !== 1'b1) bad_rd++;
            if (!mon_type_a && en) bad_en++;
            if (mon_type_a && en && wr) bad_rw++;
            if (s) begin
                strb_cnt++;
                if (cs_n) bad_cs++;
            end
            if (prev_s && !s) begin
                cap_d[cap_n % 256]   = int'(prev_d);
                cap_dc[cap_n % 256]  = int'(prev_dc);
                cap_len[cap_n % 256] = strb_cnt;
                cap_n++;
                strb_cnt = 0;
            end
        end
        prev_s  = s;
        prev_d  = dbus;
        prev_dc = dc;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
        $finish;
    end

    // Vector: mode[31:29] cp[28] nodata[27] nbytes[26:23] ts[22:19] ta[18:15] th[14:11] gap[10] cmd[7:0]
    localparam logic [31:0] VEC [9] = '{
        {3'd0, 1'b1, 1'b0, 4'd3, 4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 8'h2A},
        {3'd1, 1'b1, 1'b0, 4'd2, 4'd2, 4'd3, 4'd1, 1'b1, 2'd0, 8'h2B},
        {3'd2, 1'b0, 1'b0, 4'd4, 4'd0, 4'd0, 4'd0, 1'b0, 2'd0, 8'h00},
        {3'd3, 1'b1, 1'b0, 4'd3, 4'd1, 4'd2, 4'd2, 1'b0, 2'd0, 8'h2C},
        {3'd4, 1'b0, 1'b0, 4'd2, 4'd3, 4'd1, 4'd2, 1'b1, 2'd0, 8'h00},
        {3'd5, 1'b1, 1'b1, 4'd0, 4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 8'h29},
        {3'd0, 1'b1, 1'b1, 4'd0, 4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 8'h11},
        {3'd2, 1'b0, 1'b1, 4'd0, 4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 8'h00},
        {3'd3, 1'b1, 1'b0, 4'd1, 4'd0, 4'd4, 4'd0, 1'b0, 2'd0, 8'hF0}
    };

    function automatic int dval(input int i, input int k);
        return (16'hA5C3 ^ (i * 16'h1357) ^ (k * 16'h0F1E)) & 16'hFFFF;
    endfunction

    function automatic int mx1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic give_word(input logic [15:0] v, input bit last);
        int t;
        dvalid = 1'b1; dat = v; dlast = last;
        t = 0;
        while (t < 2000) begin
            if (dready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        dvalid = 1'b0; dlast = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t;
        t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, req, int'(busy), 0);
    endtask

    initial begin
        int base, b_en, b_rw, b_cs, b_rd, expn, msk, plen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle levels after reset
        chk(cs_n === 1'b1 && dc === 1'b0 && wr === 1'b1 && rd === 1'b1, "R8 strobes", {cs_n, dc, wr, rd}, 4'b1011);
        chk(en === 1'b0 && prst === 1'b0 && dbus === 16'h0, "R8 data", int'(dbus), 0);
        chk(busy === 1'b0 && dready === 1'b0 && err === 1'b0, "R8 status", {busy, dready, err}, 0);

        // Table of transactions
        for (int i = 0; i < 9; i++) begin
            int nb;
            bit gp;
            mode = VEC[i][31:29]; cp = VEC[i][28]; nodata = VEC[i][27];
            nb = int'(VEC[i][26:23]);
            ts = 8'(VEC[i][22:19]); ta = 8'(VEC[i][18:15]); th = 8'(VEC[i][14:11]);
            gp = VEC[i][10]; cmd = VEC[i][7:0];
            mon_type_a = (mode >= 3'd3);
            msk = (mode % 3 == 0) ? 'hFF : (mode % 3 == 1) ? 'h1FF : 'hFFFF;
            base = cap_n; b_en = bad_en; b_rw = bad_rw; b_cs = bad_cs; b_rd = bad_rd;
            pulse_start();
            chk(busy && !cs_n, "R3 window opens with busy (R11)", {busy, cs_n}, 2'b10);
            if (!nodata) begin
                for (int k = 0; k < nb; k++) begin
                    give_word(16'(dval(i, k)), k == nb - 1);
                    if (gp && k == 0) begin
                        int a;
                        repeat (20) @(negedge clk);
                        a = cap_n;
                        repeat (10) @(negedge clk);
                        chk(cap_n == a && !cs_n && dready, "R12 stall", cap_n - a, 0);
                    end
                end
            end
            wait_idle("R11 busy ends");
            expn = (cp ? 1 : 0) + (nodata ? 0 : nb);
            chk(cap_n - base == expn, "R4/R5 transfer count", cap_n - base, expn);
            if (cap_n - base == expn) begin
                for (int k = 0; k < expn; k++) begin
                    int ed, edc, di;
                    di = (base + k) % 256;
                    if (cp && k == 0) begin ed = int'(cmd); edc = 0; end
                    else begin ed = dval(i, cp ? k - 1 : k) & msk; edc = 1; end
                    chk(cap_dc[di] == edc, edc ? "R5 dc level" : "R4 dc level", cap_dc[di], edc);
                    chk(cap_d[di] == ed, "R1 word on bus", cap_d[di], ed);
                    chk(cap_len[di] == mx1(int'(ts)) + mx1(int'(ta)), "R10 strobe length",
                        cap_len[di], mx1(int'(ts)) + mx1(int'(ta)));
                end
            end
            chk(bad_cs == b_cs, "R3 strobe outside window", bad_cs - b_cs, 0);
            chk(bad_en == b_en, "R6 enable idle", bad_en - b_en, 0);
            chk(bad_rw == b_rw, "R7 rw low while enabled", bad_rw - b_rw, 0);
            chk(bad_rd == b_rd && cs_n && wr && !en, "R7 idle after close", {cs_n, wr, en}, 3'b110);
        end

        // R2: unsupported mode
        mode = 3'd6;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(err && !busy && cs_n, "R2 error pulse", {err, busy, cs_n}, 3'b101);
        @(negedge clk);
        chk(!err && cs_n && wr, "R2 single cycle", int'(err), 0);

        // R9: reset pulse length 5
        rst_len = 16'd5;
        @(negedge clk) rst_req = 1'b1;
        @(negedge clk) rst_req = 1'b0;
        plen = 0;
        while (prst && plen < 100) begin plen++; @(negedge clk); end
        chk(plen == 5, "R9 pulse length", plen, 5);
        // R9: length 0 counts as 1
        rst_len = 16'd0;
        @(negedge clk) rst_req = 1'b1;
        @(negedge clk) rst_req = 1'b0;
        plen = 0;
        while (prst && plen < 100) begin plen++; @(negedge clk); end
        chk(plen == 1, "R9 zero length", plen, 1);

        // R9: start and reset in the same cycle, reset wins; R11 start in pulse ignored
        rst_len = 16'd6; mode = 3'd0; cp = 1'b1; nodata = 1'b1; cmd = 8'h55;
        @(negedge clk) begin start = 1'b1; rst_req = 1'b1; end
        @(negedge clk) begin start = 1'b0; rst_req = 1'b0; end
        chk(prst && cs_n && busy, "R9 reset wins tie", {prst, cs_n, busy}, 3'b111);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(cs_n, "R11 start ignored in pulse", int'(cs_n), 1);
        wait_idle("R11 pulse busy");
        repeat (3) @(negedge clk);
        chk(cs_n, "R11 no late start", int'(cs_n), 1);

        // R11: requests ignored while the window is held open by a stall
        mon_type_a = 1'b0; mode = 3'd0; cp = 1'b1; nodata = 1'b0; cmd = 8'h3C;
        ts = 8'd1; ta = 8'd1; th = 8'd1; rst_len = 16'd4;
        base = cap_n;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(dready && !cs_n, "R12 waiting for word", {dready, cs_n}, 2'b10);
        @(negedge clk) rst_req = 1'b1;
        @(negedge clk) rst_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(!prst, "R11 reset ignored while busy", int'(prst), 0);
        cmd = 8'hC3;
        pulse_start();
        give_word(16'h0077, 1'b1);
        wait_idle("R11 stalled busy");
        chk(cap_n - base == 2, "R11 only one transaction", cap_n - base, 2);
        chk(cap_d[base % 256] == 'h3C && cap_d[(base + 1) % 256] == 'h77, "R11 original content",
            cap_d[base % 256], 'h3C);
        chk(!prst, "R11 no delayed reset", int'(prst), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule